// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer

This block sends a single SD-card command over a byte-wide SPI master and returns the card's one-byte R1 reply. A controller supplies a 6-bit command index and a 32-bit argument, then pulses `start`. The block builds a seven-byte command frame and passes it, one byte at a time, to an external bit shifter. It then polls for the reply, decodes it into status flags and pulses `done`.

Each byte goes through a byte-exchange stream. The block raises `xchg_valid` with the byte to send on `xchg_tx`. It holds both steady until the shifter returns `xchg_done` together with the byte clocked in on `xchg_rx`. A byte is exchanged in every cycle where `xchg_valid` and `xchg_done` are both high. The shifter may stall for any number of cycles by holding `xchg_done` low. `xchg_done` is ignored while `xchg_valid` is low.

Two options can be chosen for each command, and both are captured at `start`:
- `crc_en` selects a computed CRC7 trailer instead of a fixed one.
- `trail_en` makes the block read four extra bytes after a clean reply to the interface-condition command (index 8) or the read-operating-conditions command (index 58).

Top module: `sd_cmd_issuer`

## Requirements
- R1: While reset is held and in the first cycle after it: `busy`, `done` and `xchg_valid` are 0.
- R2: A command sends exactly seven bytes, in this order:
  - byte 0 is the filler 0xFF;
  - byte 1 is 0x40 OR the 6-bit index;
  - bytes 2 to 5 are the argument, most significant byte first;
  - byte 6 is the trailer.
- R3: With `crc_en`=1, the trailer is {crc7, 1'b1}. The CRC7 is computed over bytes 1 to 5 with polynomial x^7+x^3+1, starting from zero, MSB first. For index 8 with argument 0x1AA this gives 0x87.
- R4: With `crc_en`=0, the trailer is 0x95 whatever the index and argument.
- R5: After the frame, the block makes up to 8 poll exchanges, each sending 0xFF.
  - The first poll byte is always discarded.
  - The first later byte with bit 7 clear becomes `r1_byte`, and polling stops there.
- R6: If no poll byte is accepted, the result is `r1_byte`=0xFF and `flag_timeout`=1, with the other three flags at 0.
- R7: For an accepted reply:
  - `flag_crc` is bit 3;
  - `flag_err` is 1 when any of bits 7..1 is set;
  - `flag_idle` is bit 0.
- R8: When `trail_en`=1, the index is 8 or 58, and the accepted reply has no bit set other than bit 0, the block makes 4 more 0xFF exchanges. The bytes received are presented big-endian on `trail_word` (the first byte received lands in bits 31:24). In every other case no extra exchange takes place and `trail_word` is 0.
- R9: `busy` is high from the cycle after an accepted `start` through the single cycle in which `done` pulses. A `start` that arrives while `busy` is high is ignored. Results hold from `done` until the next accepted `start`.
- R10: Once raised, `xchg_valid` stays high, with `xchg_tx` unchanged, until `xchg_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (taken when not busy) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| crc_en | input | 1 | 1: computed CRC7 trailer; 0: fixed 0x95 |
| trail_en | input | 1 | Read 4 trailing bytes for indices 8 and 58 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| r1_byte | output | 8 | Accepted reply, or 0xFF on timeout |
| flag_timeout | output | 1 | No reply accepted |
| flag_crc | output | 1 | Reply reports a CRC error |
| flag_err | output | 1 | Reply has a bit other than idle set |
| flag_idle | output | 1 | Reply reports the idle state |
| trail_word | output | 32 | Trailing four bytes, big-endian |
| xchg_valid | output | 1 | Byte exchange requested |
| xchg_tx | output | 8 | Byte to send |
| xchg_done | input | 1 | Exchange complete this cycle |
| xchg_rx | input | 8 | Byte received in the exchange |

## Verification
The frame is exercised with several inputs:
- a zero-argument command with CRC off;
- a nonzero argument with CRC off;
- index 8 with CRC on;
- the all-ones index, which exposes any error in masking or in the start bits.

Poll scripts cover each reply path:
- a bit-7-clear first byte, which must be skipped;
- a late reply;
- an all-0xFF timeout;
- clean, error-coded and CRC-error replies, which distinguish the decode flags.

The trailing read is tried where it must happen and where it must not: a wrong index, and an error reply. A second `start` issued mid-command shows whether it is ignored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int ARG_BYTES = ARG_W / 8;
  localparam int FRAME_BYTES = ARG_BYTES + 3;

  localparam logic [7:0] FILL_BYTE     = 8'hFF;
  localparam logic [7:0] CMD_START     = 8'h40;
  localparam logic [7:0] FIXED_TRAILER = 8'h95;
  localparam logic [IDX_W-1:0] IDX_IF_COND  = 6'd8;
  localparam logic [IDX_W-1:0] IDX_READ_OCR = 6'd58;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_POLL, ST_TRAIL, ST_FIN
  } sdc_state_e;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
  parameter int MSG_BYTES = 5
) (
  input  logic [MSG_BYTES*8-1:0] msg,
  output logic [6:0]             crc
);
  localparam int MSG_BITS = MSG_BYTES * 8;
  logic [6:0] acc;
  logic       fb;

  always_comb begin
    acc = '0;
    fb  = 1'b0;
    for (int i = MSG_BITS - 1; i >= 0; i--) begin
      fb  = acc[6] ^ msg[i];
      acc = {acc[5:0], 1'b0};
      if (fb) acc = acc ^ 7'h09;
    end
    crc = acc;
  end
endmodule

// File: rtl/sdc_frame_builder.sv
module sdc_frame_builder
  import sdc_pkg::*;
#(
  parameter int SEL_W = $clog2(FRAME_BYTES)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  input  logic             crc_en,
  input  logic [SEL_W-1:0] sel,
  output logic [7:0]       byte_out
);
  logic [7:0] cmd_byte;
  logic [6:0] crc;
  logic [7:0] trailer;
  logic [7:0] frame [FRAME_BYTES];

  assign cmd_byte = CMD_START | {{(8-IDX_W){1'b0}}, idx};

  sdc_crc7 #(.MSG_BYTES(ARG_BYTES + 1)) crc_i (
    .msg({cmd_byte, arg}),
    .crc(crc)
  );

  assign trailer = crc_en ? {crc, 1'b1} : FIXED_TRAILER;

  assign frame[0] = FILL_BYTE;
  assign frame[1] = cmd_byte;
  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    assign frame[2+g] = arg[ARG_W-1-8*g -: 8];
  end
  assign frame[FRAME_BYTES-1] = trailer;

  assign byte_out = (int'(sel) < FRAME_BYTES) ? frame[sel] : FILL_BYTE;
endmodule

// File: rtl/sdc_r1_decode.sv
module sdc_r1_decode (
  input  logic [7:0] r1,
  input  logic       timed_out,
  output logic       f_crc,
  output logic       f_err,
  output logic       f_idle,
  output logic       clean
);
  assign f_crc  = !timed_out && r1[3];
  assign f_err  = !timed_out && (r1[7:1] != 7'd0);
  assign f_idle = !timed_out && r1[0];
  assign clean  = !timed_out && (r1[7:1] == 7'd0);
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
  import sdc_pkg::*;
#(
  parameter int POLL_MAX    = 8,
  parameter int TRAIL_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             crc_en,
  input  logic             trail_en,
  output logic             busy,
  output logic             done,
  output logic [7:0]       r1_byte,
  output logic             flag_timeout,
  output logic             flag_crc,
  output logic             flag_err,
  output logic             flag_idle,
  output logic [8*TRAIL_BYTES-1:0] trail_word,
  output logic             xchg_valid,
  output logic [7:0]       xchg_tx,
  input  logic             xchg_done,
  input  logic [7:0]       xchg_rx
);
  localparam int SEL_W  = $clog2(FRAME_BYTES);
  localparam int MAXC   = (POLL_MAX > FRAME_BYTES) ?
                          ((POLL_MAX > TRAIL_BYTES) ? POLL_MAX : TRAIL_BYTES) :
                          ((FRAME_BYTES > TRAIL_BYTES) ? FRAME_BYTES : TRAIL_BYTES);
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int TW     = 8 * TRAIL_BYTES;

  sdc_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] lat_idx;
  logic [ARG_W-1:0] lat_arg;
  logic             lat_crc, lat_trail;
  logic [7:0]       r1_q;
  logic             timeout_q;
  logic [TW-1:0]    trail_q;
  logic [7:0]       frame_byte;
  logic             want_trail;
  logic             rx_clean;
  logic             unused_f;

  sdc_frame_builder #(.SEL_W(SEL_W)) frame_i (
    .idx(lat_idx), .arg(lat_arg), .crc_en(lat_crc),
    .sel(cnt[SEL_W-1:0]), .byte_out(frame_byte)
  );

  sdc_r1_decode dec_out_i (
    .r1(r1_q), .timed_out(timeout_q),
    .f_crc(flag_crc), .f_err(flag_err), .f_idle(flag_idle), .clean(unused_f)
  );

  assign rx_clean   = (xchg_rx[7:1] == 7'd0);
  assign want_trail = lat_trail && (lat_idx == IDX_IF_COND || lat_idx == IDX_READ_OCR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lat_idx   <= '0;
      lat_arg   <= '0;
      lat_crc   <= 1'b0;
      lat_trail <= 1'b0;
      r1_q      <= FILL_BYTE;
      timeout_q <= 1'b0;
      trail_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          lat_idx   <= cmd_idx;
          lat_arg   <= cmd_arg;
          lat_crc   <= crc_en;
          lat_trail <= trail_en;
          r1_q      <= FILL_BYTE;
          timeout_q <= 1'b0;
          trail_q   <= '0;
          cnt       <= '0;
          state     <= ST_SEND;
        end
        ST_SEND: if (xchg_done) begin
          if (cnt == CNT_W'(FRAME_BYTES - 1)) begin
            cnt   <= '0;
            state <= ST_POLL;
          end else cnt <= cnt + 1'b1;
        end
        ST_POLL: if (xchg_done) begin
          if (cnt != '0 && !xchg_rx[7]) begin
            r1_q <= xchg_rx;
            cnt  <= '0;
            state <= (want_trail && rx_clean) ? ST_TRAIL : ST_FIN;
          end else if (cnt == CNT_W'(POLL_MAX - 1)) begin
            r1_q      <= FILL_BYTE;
            timeout_q <= 1'b1;
            state     <= ST_FIN;
          end else cnt <= cnt + 1'b1;
        end
        ST_TRAIL: if (xchg_done) begin
          trail_q <= {trail_q[TW-9:0], xchg_rx};
          if (cnt == CNT_W'(TRAIL_BYTES - 1)) state <= ST_FIN;
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_FIN);
  assign xchg_valid   = (state == ST_SEND) || (state == ST_POLL) || (state == ST_TRAIL);
  assign xchg_tx      = (state == ST_SEND) ? frame_byte : FILL_BYTE;
  assign r1_byte      = r1_q;
  assign flag_timeout = timeout_q;
  assign trail_word   = trail_q;

  p_valid_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid |-> busy);
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_valid && !xchg_done) |=> (xchg_valid && $stable(xchg_tx)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(lat_idx) && $stable(lat_arg)));
  p_timeout_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_timeout) |-> (r1_byte == 8'hFF && !flag_crc && !flag_err && !flag_idle));
  p_accept_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_timeout) |-> !r1_byte[7]);
  p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL) |-> (cnt < CNT_W'(POLL_MAX)));
endmodule

// File: tb/sd_cmd_issuer_tb_top.sv
module sd_cmd_issuer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        crc_en = 1'b0, trail_en = 1'b0;
  logic        busy, done, flag_timeout, flag_crc, flag_err, flag_idle;
  logic [7:0]  r1_byte;
  logic [31:0] trail_word;
  logic        xchg_valid, xchg_done;
  logic [7:0]  xchg_tx, xchg_rx;

  int n_tests = 0, n_fail = 0;
  int n_x;
  logic clr = 1'b0;
  logic gap;
  logic [7:0] script [32];
  logic [7:0] txlog  [32];

  always #2 clk = ~clk;

  sd_cmd_issuer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .crc_en(crc_en), .trail_en(trail_en), .busy(busy), .done(done),
    .r1_byte(r1_byte), .flag_timeout(flag_timeout), .flag_crc(flag_crc),
    .flag_err(flag_err), .flag_idle(flag_idle), .trail_word(trail_word),
    .xchg_valid(xchg_valid), .xchg_tx(xchg_tx), .xchg_done(xchg_done), .xchg_rx(xchg_rx)
  );

  // Byte shifter model: one stall cycle before each exchange completes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xchg_done <= 1'b0; xchg_rx <= 8'hFF; n_x <= 0; gap <= 1'b0;
    end else if (clr) begin
      xchg_done <= 1'b0; n_x <= 0; gap <= 1'b0;
    end else if (xchg_done) begin
      xchg_done <= 1'b0;
    end else if (xchg_valid) begin
      if (gap) begin
        xchg_done <= 1'b1;
        xchg_rx   <= script[n_x];
        txlog[n_x] <= xchg_tx;
        n_x <= n_x + 1;
        gap <= 1'b0;
      end else gap <= 1'b1;
    end
  end

  function automatic logic [7:0] ref_trailer(input logic [5:0] idx, input logic [31:0] arg,
                                              input logic en);
    logic [39:0] m;
    logic [6:0]  c;
    logic        f;
    m = {8'h40 | {2'b00, idx}, arg};
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      f = c[6] ^ m[i];
      c = {c[5:0], 1'b0};
      if (f) c = c ^ 7'h09;
    end
    return en ? {c, 1'b1} : 8'h95;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_script(input logic [7:0] polls [12], input int np);
    for (int i = 0; i < 32; i++) script[i] = 8'hFF;
    for (int i = 0; i < np; i++) script[7+i] = polls[i];
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic ce,
                       input logic te);
    int w;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    cmd_idx = idx; cmd_arg = arg; crc_en = ce; trail_en = te; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 busy after start", busy, 1);
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    check("R9 done reached", done, 1);
  endtask

  task automatic check_frame(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                             input logic ce);
    logic [7:0] exp [7];
    exp[0] = 8'hFF; exp[1] = 8'h40 | {2'b00, idx};
    exp[2] = arg[31:24]; exp[3] = arg[23:16]; exp[4] = arg[15:8]; exp[5] = arg[7:0];
    exp[6] = ref_trailer(idx, arg, ce);
    for (int i = 0; i < 7; i++) check(tag, {24'd0, txlog[i]}, {24'd0, exp[i]});
  endtask

  task automatic check_flags(input string tag, input logic [7:0] r1, input logic t,
                             input logic c, input logic e, input logic i);
    check({tag, " r1"}, {24'd0, r1_byte}, {24'd0, r1});
    check({tag, " flags"}, {28'd0, flag_timeout, flag_crc, flag_err, flag_idle},
          {28'd0, t, c, e, i});
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 xchg_valid", xchg_valid, 0);
  endtask

  task automatic t_cmd0_fixed;
    logic [7:0] p [12] = '{8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    load_script(p, 2);
    issue(6'd0, 32'd0, 1'b0, 1'b0);
    check_frame("R2 R4 cmd0 frame", 6'd0, 32'd0, 1'b0);
    check("R4 trailer 0x95", {24'd0, txlog[6]}, 32'h95);
    check("R5 exchanges", n_x, 9);
    check_flags("R7 idle reply", 8'h01, 0, 0, 0, 1);
    check("R8 no trail word", trail_word, 0);
    @(negedge clk);
    check("R9 busy clears", busy, 0);
  endtask

  task automatic t_fixed_nonzero;
    logic [7:0] p [12] = '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    load_script(p, 2);
    issue(6'd63, 32'hA5C3_1E70, 1'b0, 1'b0);
    check_frame("R2 index mask frame", 6'd63, 32'hA5C3_1E70, 1'b0);
    check("R4 trailer fixed", {24'd0, txlog[6]}, 32'h95);
    check_flags("R7 clean reply", 8'h00, 0, 0, 0, 0);
  endtask

  task automatic t_cmd8_trail;
    logic [7:0] p [12] = '{8'hFF, 8'h01, 8'h00, 8'h00, 8'h01, 8'hAA,
                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    load_script(p, 6);
    issue(6'd8, 32'h0000_01AA, 1'b1, 1'b1);
    check_frame("R3 crc frame", 6'd8, 32'h0000_01AA, 1'b1);
    check("R3 known trailer 0x87", {24'd0, txlog[6]}, 32'h87);
    check("R8 exchanges", n_x, 13);
    for (int i = 9; i < 13; i++) check("R8 trail tx FF", {24'd0, txlog[i]}, 32'hFF);
    check("R8 trail word", trail_word, 32'h0000_01AA);
    check_flags("R7 idle", 8'h01, 0, 0, 0, 1);
  endtask

  task automatic t_first_ignored;
    logic [7:0] p [12] = '{8'h00, 8'hFF, 8'hFF, 8'h05, 8'hFF, 8'hFF,
                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    load_script(p, 4);
    issue(6'd17, 32'h0000_0200, 1'b1, 1'b0);
    check("R5 first byte skipped, late reply", n_x, 11);
    for (int i = 7; i < 11; i++) check("R5 poll tx FF", {24'd0, txlog[i]}, 32'hFF);
    check_flags("R7 illegal+idle", 8'h05, 0, 0, 1, 1);
  endtask

  task automatic t_timeout;
    logic [7:0] p [12] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                           8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF};
    load_script(p, 10);
    issue(6'd58, 32'd0, 1'b1, 1'b1);
    check("R6 poll limit", n_x, 15);
    check_flags("R6 timeout", 8'hFF, 1, 0, 0, 0);
    check("R6 R8 no trail", trail_word, 0);
  endtask

  task automatic t_crc_err;
    logic [7:0] p [12] = '{8'hFF, 8'hFF, 8'h08, 8'hFF, 8'hFF, 8'hFF,
                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    load_script(p, 3);
    issue(6'd8, 32'h0000_01AA, 1'b1, 1'b1);
    check("R8 no trail on error reply", n_x, 10);
    check("R8 trail word zero", trail_word, 0);
    check_flags("R7 crc error", 8'h08, 0, 1, 1, 0);
  endtask

  task automatic t_trail_wrong_idx;
    logic [7:0] p [12] = '{8'hFF, 8'h01, 8'h12, 8'h34, 8'h56, 8'h78,
                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    load_script(p, 6);
    issue(6'd17, 32'h0, 1'b1, 1'b1);
    check("R8 no trail other index", n_x, 9);
    check("R8 trail word zero idx", trail_word, 0);
  endtask

  task automatic t_start_busy;
    logic [7:0] p [12] = '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    int w;
    load_script(p, 2);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    cmd_idx = 6'd24; cmd_arg = 32'h0000_1000; crc_en = 1'b1; trail_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    cmd_idx = 6'd12; cmd_arg = 32'hFFFF_FFFF; crc_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    check_frame("R9 start ignored frame", 6'd24, 32'h0000_1000, 1'b1);
    repeat (20) @(negedge clk);
    check("R9 no second command", n_x, 9);
    check("R9 idle after", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd0_fixed();
    t_fixed_nonzero();
    t_cmd8_trail();
    t_first_ignored();
    t_timeout();
    t_crc_err();
    t_trail_wrong_idx();
    t_start_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule